// File: doc/BRIEF.md
# Reloading Interval Timer with Suspend Wake-Up

This block is a 16-bit up-counter that software reaches one byte at a time through a small register bank. When the count passes its all-ones value it is refilled from a 16-bit reload pair instead of returning to zero. This gives a repeating period that software can program. Each advance of the count comes from one of three tick sources: every system clock, one system clock in twelve, or one period in eight of a free-running external clock. The external source is brought into the system clock domain through a synchronizer. Sticky flags record wraps of the full word and of the low byte, and a single interrupt line is driven from those flags.

While the suspend input is high, only the external source advances the count, and one synchronizer stage is skipped so that ticks arrive with less delay. A full-word wrap during suspend raises a wake request. When suspend ends for any other reason, a busy status bit stays high while the external path settles again. During that time, writes to the counter bytes are dropped and reads of them return a frozen copy.

Top module: `reload_timer`

## Requirements
- R1: After reset every register reads zero, and irq, wake and sync_busy are low.
- R2: Address 1 holds the counter low byte, 2 the counter high byte, 3 the reload low byte, 4 the reload high byte, 0 the control byte and 5 the status byte (bit 0 busy, bit 1 wake, others zero). A write takes effect at the clock edge that samples wr_en, and rdata follows addr without a clock.
- R3: Control bits 1:0 choose the tick: 0 is one in twelve system clocks, 1 is every system clock, 2 or 3 is the external clock divided by 8. Control bit 2 is run. With run set and source 1, the counter rises by one at every clock edge.
- R4: With source 0, the first count comes on the twelfth edge after run is set and then one every twelve edges. Clearing run restarts the divide-by-12 phase from zero.
- R5: With run clear, the counter holds its value.
- R6: A tick at count 0xFFFF loads the reload value and sets the high wrap flag (control bit 7) on the same edge.
- R7: A tick while the low byte is 0xFF sets the low wrap flag (control bit 6), whether or not it is a full-word wrap.
- R8: The wrap flags are sticky. Writing 0 to a flag bit clears it and writing 1 leaves it as it is. A wrap on the same edge as a clearing write leaves the flag set.
- R9: irq is high when control bit 4 is set and either the high flag is set, or control bit 5 and the low flag are both set.
- R10: With source 2, the counter advances once per eight external clock periods, after synchronization.
- R11: While suspend is high, only external ticks count. A full-word wrap then sets wake, which stays high until suspend falls.
- R12: When suspend falls with wake low, sync_busy rises on that edge and stays high for three synchronized external ticks. While it is high, counter byte writes are ignored and counter reads return the value held when busy began.
- R13: Control bit 3 (split mode) always reads 0, and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| ext_clk | input | 1 | Free-running external clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| suspend | input | 1 | High while the system is suspended |
| wr_en | input | 1 | Byte write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr |
| irq | output | 1 | Interrupt request |
| wake | output | 1 | Wake request from a wrap during suspend |
| sync_busy | output | 1 | External path resynchronizing; counter access not valid |

## Verification
The bench drives inputs on the falling clock edge and samples half a cycle after each rising edge. It counts the rising edges after the one that accepted the run write: with the system-clock source the count is start plus that number, and with the divide-by-12 source it changes on edge 12 and edge 24. Flags, irq and the reload load appear on the same edge as the wrapping tick. Wake appears on the wrapping edge, and busy appears on the edge where suspend is seen low. Because the external clock is asynchronous and the synchronizer adds two or three cycles, the external count is checked against a window of one tick either side, and the wake request is polled with a bound.

// File: rtl/rt_pkg.sv
package rt_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 3;

    typedef enum logic [1:0] {
        SRC_DIV12   = 2'd0,
        SRC_SYS     = 2'd1,
        SRC_EXT     = 2'd2,
        SRC_EXT_ALT = 2'd3
    } src_e;

    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd1;
    localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd2;
    localparam logic [ADDR_W-1:0] A_RLD_LO = 3'd3;
    localparam logic [ADDR_W-1:0] A_RLD_HI = 3'd4;
    localparam logic [ADDR_W-1:0] A_STAT   = 3'd5;

    localparam int B_FHI   = 7;
    localparam int B_FLO   = 6;
    localparam int B_LOIE  = 5;
    localparam int B_IE    = 4;
    localparam int B_SPLIT = 3;
    localparam int B_RUN   = 2;
endpackage

// File: rtl/rt_prescale.sv
module rt_prescale #(
    parameter int DIV = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int PW = $clog2(DIV);
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    typedef struct packed {
        logic [PW-1:0] cnt;
    } pre_t;

    pre_t pre_d, pre_q;

    always_comb begin
        pre_d = pre_q;
        if (!en || pre_q.cnt == LAST) begin
            pre_d.cnt = '0;
        end else begin
            pre_d.cnt = pre_q.cnt + PW'(1);
        end
    end

    assign tick = en && (pre_q.cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_d;
        end
    end

    // R4: a divided tick is a single-cycle enable
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    // R4: stopping returns the phase to zero
    a_r4_phase_restart: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> pre_q.cnt == '0);
endmodule

// File: rtl/rt_ext_sync.sv
module rt_ext_sync #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic ext_clk,
    input  logic rst_n,
    input  logic suspend,
    output logic tick
);
    localparam int DW = $clog2(DIV);

    logic [DW-1:0] div_q;
    logic          level;

    always_ff @(posedge ext_clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + DW'(1);
        end
    end

    assign level = div_q[DW-1];

    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } syn_t;

    syn_t syn_d, syn_q;

    always_comb begin
        syn_d    = syn_q;
        syn_d.s1 = level;
        syn_d.s2 = syn_q.s1;
        syn_d.s3 = suspend ? syn_q.s1 : syn_q.s2;
    end

    assign tick = suspend ? (syn_q.s1 && !syn_q.s3) : (syn_q.s2 && !syn_q.s3);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            syn_q <= '0;
        end else begin
            syn_q <= syn_d;
        end
    end

    // R10: one tick per external edge, never two in a row
    a_r10_single_tick: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/rt_core.sv
module rt_core
    import rt_pkg::*;
#(
    parameter int BUSY_TICKS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              tick,
    input  logic              ext_tick,
    input  logic              suspend,
    output logic [DATA_W-1:0] rdata,
    output logic              run,
    output logic [1:0]        src,
    output logic              irq,
    output logic              wake,
    output logic              busy
);
    localparam int CW = 2 * DATA_W;
    localparam int BW = $clog2(BUSY_TICKS + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [CW-1:0] rld;
        logic [CW-1:0] snap;
        logic          fhi;
        logic          flo;
        logic          loie;
        logic          ie;
        logic          run;
        logic [1:0]    src;
        logic          susp;
        logic          wake;
        logic [BW-1:0] busy_cnt;
    } core_t;

    core_t core_d, core_q;

    logic          cnt_we_lo, cnt_we_hi, ctrl_we;
    logic          ovf_hi, ovf_lo, leave;
    logic [CW-1:0] cnt_view;
    logic          unused_split;

    assign unused_split = wdata[B_SPLIT];
    assign busy      = core_q.busy_cnt != '0;
    assign ctrl_we   = wr_en && addr == A_CTRL;
    assign cnt_we_lo = wr_en && addr == A_CNT_LO && !busy;
    assign cnt_we_hi = wr_en && addr == A_CNT_HI && !busy;
    assign leave     = core_q.susp && !suspend;

    always_comb begin
        core_d = core_q;
        ovf_hi = 1'b0;
        ovf_lo = 1'b0;

        if (wr_en) begin
            case (addr)
                A_CTRL: begin
                    core_d.loie = wdata[B_LOIE];
                    core_d.ie   = wdata[B_IE];
                    core_d.run  = wdata[B_RUN];
                    core_d.src  = wdata[1:0];
                    if (!wdata[B_FHI]) core_d.fhi = 1'b0;
                    if (!wdata[B_FLO]) core_d.flo = 1'b0;
                end
                A_RLD_LO: core_d.rld[DATA_W-1:0]  = wdata;
                A_RLD_HI: core_d.rld[CW-1:DATA_W] = wdata;
                default: ;
            endcase
        end

        if (tick) begin
            ovf_lo = core_q.cnt[DATA_W-1:0] == '1;
            if (core_q.cnt == '1) begin
                ovf_hi     = 1'b1;
                core_d.cnt = core_q.rld;
            end else begin
                core_d.cnt = core_q.cnt + CW'(1);
            end
        end
        if (cnt_we_lo) core_d.cnt[DATA_W-1:0]  = wdata;
        if (cnt_we_hi) core_d.cnt[CW-1:DATA_W] = wdata;

        if (ovf_hi) core_d.fhi = 1'b1;
        if (ovf_lo) core_d.flo = 1'b1;

        core_d.susp = suspend;
        if (ovf_hi && suspend) begin
            core_d.wake = 1'b1;
        end else if (!suspend) begin
            core_d.wake = 1'b0;
        end

        if (leave && !core_q.wake) begin
            core_d.busy_cnt = BW'(BUSY_TICKS);
        end else if (busy && ext_tick) begin
            core_d.busy_cnt = core_q.busy_cnt - BW'(1);
        end

        core_d.snap = busy ? core_q.snap : core_q.cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q <= '0;
        end else begin
            core_q <= core_d;
        end
    end

    assign cnt_view = busy ? core_q.snap : core_q.cnt;

    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL:   rdata = {core_q.fhi, core_q.flo, core_q.loie, core_q.ie,
                               1'b0, core_q.run, core_q.src};
            A_CNT_LO: rdata = cnt_view[DATA_W-1:0];
            A_CNT_HI: rdata = cnt_view[CW-1:DATA_W];
            A_RLD_LO: rdata = core_q.rld[DATA_W-1:0];
            A_RLD_HI: rdata = core_q.rld[CW-1:DATA_W];
            A_STAT:   rdata = {{(DATA_W-2){1'b0}}, core_q.wake, busy};
            default:  rdata = '0;
        endcase
    end

    assign run  = core_q.run;
    assign src  = core_q.src;
    assign wake = core_q.wake;
    assign irq  = core_q.ie && (core_q.fhi || (core_q.loie && core_q.flo));

    // R6: a full-word wrap loads the reload value and raises the high flag
    a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
        tick && core_q.cnt == '1 && !cnt_we_lo && !cnt_we_hi
        |=> core_q.cnt == $past(core_q.rld) && core_q.fhi);
    // R5: without a tick or a write the count is frozen
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tick && !cnt_we_lo && !cnt_we_hi |=> $stable(core_q.cnt));
    // R8: the high flag survives anything but a clearing write
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        core_q.fhi && !(ctrl_we && !wdata[B_FHI]) |=> core_q.fhi);
    // R12: byte writes during busy do not reach the counter
    a_r12_busy_write: assert property (@(posedge clk) disable iff (!rst_n)
        busy && wr_en && addr == A_CNT_LO && !tick
        |=> $stable(core_q.cnt[DATA_W-1:0]));
    // R11: wake only rises while suspended
    a_r11_wake_in_suspend: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_q.wake) |-> $past(suspend));
endmodule

// File: rtl/reload_timer.sv
module reload_timer
    import rt_pkg::*;
#(
    parameter int PRESC_DIV  = 12,
    parameter int EXT_DIV    = 8,
    parameter int BUSY_TICKS = 3
) (
    input  logic              clk,
    input  logic              ext_clk,
    input  logic              rst_n,
    input  logic              suspend,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq,
    output logic              wake,
    output logic              sync_busy
);
    logic       run;
    logic [1:0] src;
    logic       p_tick, e_tick, cnt_tick;

    rt_prescale #(.DIV(PRESC_DIV)) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (run),
        .tick (p_tick)
    );

    rt_ext_sync #(.DIV(EXT_DIV)) u_ext (
        .clk    (clk),
        .ext_clk(ext_clk),
        .rst_n  (rst_n),
        .suspend(suspend),
        .tick   (e_tick)
    );

    always_comb begin
        cnt_tick = 1'b0;
        if (run) begin
            if (suspend) begin
                cnt_tick = e_tick;
            end else begin
                case (src_e'(src))
                    SRC_DIV12: cnt_tick = p_tick;
                    SRC_SYS:   cnt_tick = 1'b1;
                    default:   cnt_tick = e_tick;
                endcase
            end
        end
    end

    rt_core #(.BUSY_TICKS(BUSY_TICKS)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .tick    (cnt_tick),
        .ext_tick(e_tick),
        .suspend (suspend),
        .rdata   (rdata),
        .run     (run),
        .src     (src),
        .irq     (irq),
        .wake    (wake),
        .busy    (sync_busy)
    );

    // R11: system-derived ticks never count during suspend
    a_r11_ext_only: assert property (@(posedge clk) disable iff (!rst_n)
        suspend && !e_tick |-> !cnt_tick);
endmodule

// File: tb/tb_reload_timer.sv
`timescale 1ns/1ps
module tb_reload_timer;
    logic       clk = 1'b0;
    logic       ext_clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       suspend = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       irq, wake, sync_busy;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  done = 1'b0;

    always #10 clk = ~clk;
    always #30 ext_clk = ~ext_clk;

    reload_timer dut (
        .clk(clk), .ext_clk(ext_clk), .rst_n(rst_n), .suspend(suspend),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .irq(irq), .wake(wake), .sync_busy(sync_busy)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] v);
        wr_en = 1'b1; addr = a; wdata = v;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic tick_n(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), v);
            check("R1 register reset", 16'(v), 16'h0);
        end
        check("R1 irq reset", 16'(irq), 16'h0);
        check("R1 wake reset", 16'(wake), 16'h0);
        check("R1 busy reset", 16'(sync_busy), 16'h0);
    endtask

    task automatic t_regs;
        logic [7:0] v;
        wr(3'd3, 8'h34); wr(3'd4, 8'h12);
        wr(3'd1, 8'hAB); wr(3'd2, 8'hCD);
        rd(3'd3, v); check("R2 reload low", 16'(v), 16'h34);
        rd(3'd4, v); check("R2 reload high", 16'(v), 16'h12);
        rd(3'd1, v); check("R2 count low", 16'(v), 16'hAB);
        rd(3'd2, v); check("R2 count high", 16'(v), 16'hCD);
        wr(3'd0, 8'h08);
        rd(3'd0, v); check("R13 split reads zero", 16'(v), 16'h00);
    endtask

    task automatic t_sysclk;
        logic [7:0] v;
        wr(3'd1, 8'h10); wr(3'd2, 8'h00);
        wr(3'd0, 8'h05);
        tick_n(5);
        rd(3'd1, v); check("R3 sysclk count", 16'(v), 16'h15);
        wr(3'd0, 8'h01);
        tick_n(10);
        rd(3'd1, v); check("R5 hold when stopped", 16'(v), 16'h16);
    endtask

    task automatic t_div12;
        logic [7:0] v;
        wr(3'd1, 8'h00);
        wr(3'd0, 8'h04);
        tick_n(11);
        rd(3'd1, v); check("R4 no count before edge 12", 16'(v), 16'h00);
        tick_n(1);
        rd(3'd1, v); check("R4 first count at edge 12", 16'(v), 16'h01);
        tick_n(12);
        rd(3'd1, v); check("R4 second count at edge 24", 16'(v), 16'h02);
        tick_n(5);
        wr(3'd0, 8'h00);
        tick_n(4);
        wr(3'd0, 8'h04);
        tick_n(11);
        rd(3'd1, v); check("R4 phase restarted", 16'(v), 16'h02);
        tick_n(1);
        rd(3'd1, v); check("R4 count after restart", 16'(v), 16'h03);
        wr(3'd0, 8'h00);
    endtask

    task automatic t_overflow;
        logic [7:0] v;
        wr(3'd1, 8'hFE); wr(3'd2, 8'hFF);
        wr(3'd0, 8'h35);
        tick_n(1);
        rd(3'd2, v); check("R6 before wrap", 16'(v), 16'hFF);
        rd(3'd0, v); check("R6 no flags yet", 16'(v), 16'h35);
        check("R9 irq low before wrap", 16'(irq), 16'h0);
        tick_n(1);
        rd(3'd1, v); check("R6 reload low", 16'(v), 16'h34);
        rd(3'd2, v); check("R6 reload high", 16'(v), 16'h12);
        rd(3'd0, v); check("R6 R7 both flags", 16'(v), 16'hF5);
        check("R9 irq on wrap", 16'(irq), 16'h1);
        check("R11 no wake outside suspend", 16'(wake), 16'h0);
        wr(3'd0, 8'hF1);
        wr(3'd0, 8'hB0);
        rd(3'd0, v); check("R8 low flag cleared alone", 16'(v), 16'hB0);
        check("R9 irq from high flag", 16'(irq), 16'h1);
        wr(3'd0, 8'h30);
        rd(3'd0, v); check("R8 high flag cleared", 16'(v), 16'h30);
        check("R9 irq drops", 16'(irq), 16'h0);
    endtask

    task automatic t_low_wrap;
        logic [7:0] v;
        wr(3'd1, 8'hFF); wr(3'd2, 8'h00);
        wr(3'd0, 8'h25);
        tick_n(1);
        rd(3'd2, v); check("R7 carry into high byte", 16'(v), 16'h01);
        rd(3'd0, v); check("R7 low flag only", 16'(v), 16'h65);
        check("R9 no irq without enable", 16'(irq), 16'h0);
        wr(3'd0, 8'h71);
        check("R9 irq from low flag", 16'(irq), 16'h1);
        wr(3'd0, 8'h51);
        check("R9 low flag masked", 16'(irq), 16'h0);
        wr(3'd0, 8'h00);
    endtask

    task automatic t_set_wins;
        logic [7:0] v;
        wr(3'd1, 8'hFF); wr(3'd2, 8'hFF);
        wr(3'd0, 8'h05);
        wr(3'd0, 8'h05);
        rd(3'd0, v); check("R8 set beats clear", 16'(v), 16'hC5);
        wr(3'd0, 8'h01);
        wr(3'd0, 8'h00);
    endtask

    task automatic t_ext;
        logic [7:0] v;
        wr(3'd1, 8'h00); wr(3'd2, 8'h00);
        wr(3'd0, 8'h06);
        tick_n(240);
        rd(3'd1, v);
        n_vec++;
        if (v < 8'd9 || v > 8'd11) begin
            n_bad++;
            $display("FAIL R10 external count: got %0d expected 9..11", v);
        end
        wr(3'd0, 8'h02);
    endtask

    task automatic t_wake;
        logic [7:0] v;
        wr(3'd1, 8'hFC); wr(3'd2, 8'hFF);
        suspend = 1'b1;
        wr(3'd0, 8'h06);
        check("R11 wake low at start", 16'(wake), 16'h0);
        for (int i = 0; i < 600 && !wake; i++) tick_n(1);
        check("R11 wake on wrap in suspend", 16'(wake), 16'h1);
        rd(3'd0, v); check("R11 high flag in suspend", 16'(v[7]), 16'h1);
        suspend = 1'b0;
        tick_n(1);
        check("R11 wake clears", 16'(wake), 16'h0);
        check("R12 no busy after timer wake", 16'(sync_busy), 16'h0);
        wr(3'd0, 8'h02);
    endtask

    task automatic t_busy;
        logic [7:0] v0, v;
        wr(3'd0, 8'h00);
        rd(3'd1, v0);
        suspend = 1'b1;
        tick_n(3);
        suspend = 1'b0;
        tick_n(1);
        rd(3'd5, v); check("R12 busy status", 16'(v), 16'h01);
        check("R12 busy port", 16'(sync_busy), 16'h1);
        wr(3'd1, v0 ^ 8'hFF);
        rd(3'd1, v); check("R12 write ignored while busy", 16'(v), 16'(v0));
        tick_n(200);
        check("R12 busy ends", 16'(sync_busy), 16'h0);
        rd(3'd1, v); check("R12 value unchanged after busy", 16'(v), 16'(v0));
        wr(3'd1, 8'h5A);
        rd(3'd1, v); check("R12 write accepted after busy", 16'(v), 16'h5A);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_sysclk();
        t_div12();
        t_overflow();
        t_low_wrap();
        t_set_wins();
        t_ext();
        t_wake();
        t_busy();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule